// File: doc/BRIEF.md
# SPI Register and Scratch-RAM Slave

This block is a serial slave that runs in SPI mode 0. It gives byte-wide access to two internal regions. The first is a 32-byte register file at addresses 0x00 to 0x1F, which holds clock and calendar state. The second is a 64-byte scratch SRAM at addresses 0x20 to 0x5F. A host pulls `cs_n` low and sends an instruction byte, then an address byte, both most significant bit first. It then streams any number of data bytes in or out. An internal pointer advances after every data byte and stays inside the region the transfer started in. A separate instruction zeroes the whole scratch SRAM.

The serial pins are asynchronous to `clk`. Each pin passes through a synchronizer before any edge is detected, so the SCK rate must be well below the `clk` rate. The `on_battery` input says whether the device runs from its backup supply. While it is high, the block rejects all host traffic.

Top module: `spi_mem_slave`

## Requirements
- R1: Instruction 0x13 starts a read and 0x12 starts a write. The instruction is followed by an 8-bit address. Read data leaves on `so`, most significant bit first, from the falling SCK edge that ends the address byte.
- R2: `so_oe` is low during reset, while `cs_n` is high, and while the instruction and address bytes are being clocked in.
- R3: During a read or write burst, the pointer advances by one after each data byte, for as long as clocks continue.
- R4: A pointer inside the SRAM region (0x20..0x5F) moves from 0x5F back to 0x20.
- R5: A pointer inside the register region (0x00..0x1F) moves from 0x1F back to 0x00. All registers read 0x00 after reset.
- R6: Addresses 0x60..0xFF read as 0x00 and ignore writes. In this range the pointer simply increments, and after 0xFF it comes back to 0x00.
- R7: A write needs no prior enable. Every data byte that is fully clocked in is stored. The last byte is stored when `cs_n` rises on a byte boundary.
- R8: If `cs_n` rises partway through a data byte, that byte is discarded and the location keeps its old value.
- R9: While `on_battery` is high, reads, writes and clears have no effect and `so_oe` stays low. A transaction is abandoned if `on_battery` rises during it.
- R10: The final byte of a write is stored on the third rising `clk` edge after `cs_n` rises (with the default two-stage synchronizer). If `on_battery` is high on that edge or on any earlier edge, the byte is discarded.
- R11: Instruction 0x54 writes 0x00 to all 64 SRAM bytes and leaves the registers unchanged.
- R12: Any other instruction byte is ignored until `cs_n` rises. Nothing is written and `so_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; frames each transaction |
| sck | input | 1 | Serial clock, idles low (mode 0) |
| si | input | 1 | Serial data from the host, sampled on rising SCK |
| on_battery | input | 1 | High while the device runs from its backup supply |
| so | output | 1 | Serial data to the host, changes after falling SCK |
| so_oe | output | 1 | Output enable for the `so` pad driver; low means high-impedance |

## Verification
Two events can fall in the same `clk` cycle: the commit of the final write byte, triggered by the synchronized rising edge of `cs_n`, and the arrival of the battery supply. The bench provokes this by raising `on_battery` 0 to 5 falling `clk` edges after `cs_n` goes high. For each offset it computes from R10 whether the byte must survive, and it reads the location back once the supply returns. The offsets at 2 and 3 put the battery edge in the commit cycle and the cycle after it, so an off-by-one in either the gating or the synchronizer depth shows up as a wrong read-back value.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam logic [7:0] OP_READ  = 8'h13;
  localparam logic [7:0] OP_WRITE = 8'h12;
  localparam logic [7:0] OP_CLEAR = 8'h54;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_WR,
    ST_RD,
    ST_SKIP
  } xfer_state_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic cs_rise,
  output logic cs_fall,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s
);

  localparam int LANES = 3;
  // lane order {cs_n, sck, si}; chip select idles high
  localparam logic [LANES-1:0] LANE_RST = 3'b100;

  logic [LANES-1:0] pins_in;
  logic [LANES-1:0] synced;
  logic [1:0]       edge_q;

  assign pins_in = {cs_n, sck, si};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {STAGES{LANE_RST[g]}};
      else        pipe_q <= {pipe_q[STAGES-2:0], pins_in[g]};
    end
    assign synced[g] = pipe_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_q <= LANE_RST[2:1];
    else        edge_q <= synced[2:1];
  end

  assign cs_rise  =  synced[2] & ~edge_q[1];
  assign cs_fall  = ~synced[2] &  edge_q[1];
  assign sck_rise =  synced[1] & ~edge_q[0];
  assign sck_fall = ~synced[1] &  edge_q[0];
  assign si_s     =  synced[0];

endmodule

// File: rtl/spi_addr_map.sv
module spi_addr_map #(
  parameter int AW         = 8,
  parameter int REG_BYTES  = 32,
  parameter int SRAM_BASE  = 32,
  parameter int SRAM_BYTES = 64
) (
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] next,
  output logic          in_reg,
  output logic          in_sram
);

  localparam logic [AW-1:0] REG_LAST   = AW'(REG_BYTES - 1);
  localparam logic [AW-1:0] SRAM_FIRST = AW'(SRAM_BASE);
  localparam logic [AW-1:0] SRAM_LAST  = AW'(SRAM_BASE + SRAM_BYTES - 1);

  assign in_reg  = (addr <= REG_LAST);
  assign in_sram = (addr >= SRAM_FIRST) && (addr <= SRAM_LAST);

  always_comb begin
    if (in_reg)       next = (addr == REG_LAST)  ? '0         : addr + 1'b1;
    else if (in_sram) next = (addr == SRAM_LAST) ? SRAM_FIRST : addr + 1'b1;
    else              next = addr + 1'b1;
  end

endmodule

// File: rtl/spi_mem_store.sv
module spi_mem_store #(
  parameter int AW         = 8,
  parameter int REG_BYTES  = 32,
  parameter int SRAM_BASE  = 32,
  parameter int SRAM_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          clr,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  localparam int REG_AW  = $clog2(REG_BYTES);
  localparam int SRAM_AW = $clog2(SRAM_BYTES);
  localparam logic [AW-1:0] REG_LAST   = AW'(REG_BYTES - 1);
  localparam logic [AW-1:0] SRAM_FIRST = AW'(SRAM_BASE);
  localparam logic [AW-1:0] SRAM_LAST  = AW'(SRAM_BASE + SRAM_BYTES - 1);

  logic [7:0] regs_q [REG_BYTES];
  logic [7:0] sram_q [SRAM_BYTES];

  logic               w_in_reg, w_in_sram, r_in_reg, r_in_sram;
  logic [SRAM_AW-1:0] woff, roff;

  assign w_in_reg  = (waddr <= REG_LAST);
  assign w_in_sram = (waddr >= SRAM_FIRST) && (waddr <= SRAM_LAST);
  assign r_in_reg  = (raddr <= REG_LAST);
  assign r_in_sram = (raddr >= SRAM_FIRST) && (raddr <= SRAM_LAST);
  assign woff      = SRAM_AW'(waddr - SRAM_FIRST);
  assign roff      = SRAM_AW'(raddr - SRAM_FIRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_BYTES; i++) regs_q[i] <= 8'h00;
    end else if (we && w_in_reg) begin
      regs_q[waddr[REG_AW-1:0]] <= wdata;
    end
  end

  // scratch array has no reset: contents are undefined until cleared
  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < SRAM_BYTES; i++) sram_q[i] <= 8'h00;
    end else if (we && w_in_sram) begin
      sram_q[woff] <= wdata;
    end
  end

  always_comb begin
    if (r_in_reg)       rdata = regs_q[raddr[REG_AW-1:0]];
    else if (r_in_sram) rdata = sram_q[roff];
    else                rdata = 8'h00;
  end

  // R11
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sram_q[0] == 8'h00 && sram_q[SRAM_BYTES-1] == 8'h00));

  // R11
  clear_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ($stable(regs_q[0]) && $stable(regs_q[REG_BYTES-1])));

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 8,
  parameter int REG_BYTES   = 32,
  parameter int SRAM_BASE   = 32,
  parameter int SRAM_BYTES  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic on_battery,
  output logic so,
  output logic so_oe
);

  logic cs_rise, cs_fall, sck_rise, sck_fall, si_s;

  xfer_state_e   state_q;
  logic [2:0]    bitcnt_q, outcnt_q;
  logic [6:0]    shreg_q, out_q;
  logic          is_wr_q, pend_q, so_q, so_oe_q;
  logic [AW-1:0] ptr_q, pend_addr_q, ptr_nxt;
  logic [7:0]    pend_data_q, byte_in, rd_data;
  logic          ptr_in_reg, ptr_in_sram;
  logic          live, shifting, byte_done, rd_step, ptr_adv, mem_we, clr;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sck      (sck),
    .si       (si),
    .cs_rise  (cs_rise),
    .cs_fall  (cs_fall),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .si_s     (si_s)
  );

  spi_addr_map #(
    .AW(AW), .REG_BYTES(REG_BYTES), .SRAM_BASE(SRAM_BASE), .SRAM_BYTES(SRAM_BYTES)
  ) u_map (
    .addr    (ptr_q),
    .next    (ptr_nxt),
    .in_reg  (ptr_in_reg),
    .in_sram (ptr_in_sram)
  );

  spi_mem_store #(
    .AW(AW), .REG_BYTES(REG_BYTES), .SRAM_BASE(SRAM_BASE), .SRAM_BYTES(SRAM_BYTES)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (pend_addr_q),
    .wdata (pend_data_q),
    .clr   (clr),
    .raddr (ptr_q),
    .rdata (rd_data)
  );

  assign byte_in   = {shreg_q, si_s};
  assign live      = !on_battery && !cs_rise && !cs_fall;
  assign shifting  = (state_q == ST_CMD) || (state_q == ST_ADDR) || (state_q == ST_WR);
  assign byte_done = live && sck_rise && shifting && (bitcnt_q == 3'd7);
  assign rd_step   = live && sck_fall && (state_q == ST_RD);
  assign ptr_adv   = (byte_done && state_q == ST_WR) || (rd_step && outcnt_q == 3'd0);
  // a held byte is written when the next byte starts or when select ends
  assign mem_we    = pend_q && !on_battery && (cs_rise || (sck_rise && state_q == ST_WR));
  assign clr       = byte_done && (state_q == ST_CMD) && (byte_in == OP_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      bitcnt_q    <= '0;
      outcnt_q    <= '0;
      shreg_q     <= '0;
      out_q       <= '0;
      is_wr_q     <= 1'b0;
      pend_q      <= 1'b0;
      so_q        <= 1'b0;
      so_oe_q     <= 1'b0;
      ptr_q       <= '0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else if (on_battery || cs_rise) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      outcnt_q <= '0;
      pend_q   <= 1'b0;
      so_oe_q  <= 1'b0;
    end else if (cs_fall) begin
      state_q  <= ST_CMD;
      bitcnt_q <= '0;
      outcnt_q <= '0;
      pend_q   <= 1'b0;
      so_oe_q  <= 1'b0;
    end else begin
      if (sck_rise && shifting) begin
        shreg_q  <= byte_in[6:0];
        bitcnt_q <= bitcnt_q + 3'd1;
        pend_q   <= 1'b0;
      end
      if (byte_done) begin
        case (state_q)
          ST_CMD: begin
            if (byte_in == OP_READ) begin
              is_wr_q <= 1'b0;
              state_q <= ST_ADDR;
            end else if (byte_in == OP_WRITE) begin
              is_wr_q <= 1'b1;
              state_q <= ST_ADDR;
            end else begin
              state_q <= ST_SKIP;
            end
          end
          ST_ADDR: begin
            ptr_q   <= byte_in[AW-1:0];
            state_q <= is_wr_q ? ST_WR : ST_RD;
          end
          ST_WR: begin
            pend_q      <= 1'b1;
            pend_addr_q <= ptr_q;
            pend_data_q <= byte_in;
            ptr_q       <= ptr_nxt;
          end
          default: ;
        endcase
      end
      if (rd_step) begin
        so_oe_q <= 1'b1;
        if (outcnt_q == 3'd0) begin
          so_q     <= rd_data[7];
          out_q    <= rd_data[6:0];
          outcnt_q <= 3'd7;
          ptr_q    <= ptr_nxt;
        end else begin
          so_q     <= out_q[6];
          out_q    <= {out_q[5:0], 1'b0};
          outcnt_q <= outcnt_q - 3'd1;
        end
      end
    end
  end

  assign so    = so_q;
  assign so_oe = so_oe_q;

  // R2
  hiz_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMD || state_q == ST_ADDR) |-> !so_oe_q);

  // R9
  batt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_battery |=> !so_oe_q);

  // R5
  reg_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_adv && ptr_in_reg) |=> ptr_in_reg);

  // R4
  sram_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_adv && ptr_in_sram) |=> ptr_in_sram);

  // R8
  partial_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && state_q == ST_WR && bitcnt_q != 3'd0) |-> !mem_we);

  // R12
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> (!mem_we && !so_oe_q));

endmodule

// File: tb/test_spi_mem_slave.sv
module test_spi_mem_slave;

  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic on_battery = 1'b0;
  logic so, so_oe;

  int checks = 0;
  int errors = 0;
  logic oe_any;
  logic [7:0] mreg  [32];
  logic [7:0] msram [64];

  always #10 clk = ~clk;

  spi_mem_slave i_spi_mem_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .on_battery(on_battery), .so(so), .so_oe(so_oe)
  );

  function automatic logic [7:0] nxt(input logic [7:0] a);
    if (a <= 8'h1F) return (a == 8'h1F) ? 8'h00 : a + 8'd1;
    if (a <= 8'h5F) return (a == 8'h5F) ? 8'h20 : a + 8'd1;
    return a + 8'd1;
  endfunction

  function automatic logic [7:0] mread(input logic [7:0] a);
    if (a <= 8'h1F) return mreg[a[4:0]];
    if (a <= 8'h5F) return msram[6'(a - 8'h20)];
    return 8'h00;
  endfunction

  task automatic mwrite(input logic [7:0] a, input logic [7:0] v);
    if (a <= 8'h1F) mreg[a[4:0]] = v;
    else if (a <= 8'h5F) msram[6'(a - 8'h20)] = v;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int nbits);
    rx = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      si = tx[i];
      repeat (HP) @(negedge clk);
      rx[i] = so;
      oe_any = oe_any | so_oe;
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic begin_tx();
    @(negedge clk);
    cs_n = 1'b0;
    oe_any = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic end_tx();
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic read_seq(input logic [7:0] a, input int n, input string req);
    logic [7:0] p, rx;
    p = a;
    begin_tx();
    xfer(8'h13, rx, 8);
    xfer(a, rx, 8);
    chk("R2 header high-impedance", {7'd0, oe_any}, 8'h00);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, rx, 8);
      chk(req, rx, mread(p));
      p = nxt(p);
    end
    end_tx();
  endtask

  task automatic write_seq(input logic [7:0] a, input int n, input logic [7:0] seed);
    logic [7:0] p, rx, v;
    p = a;
    begin_tx();
    xfer(8'h12, rx, 8);
    xfer(a, rx, 8);
    for (int i = 0; i < n; i++) begin
      v = p * 8'd7 + seed;
      xfer(v, rx, 8);
      mwrite(p, v);
      p = nxt(p);
    end
    end_tx();
  endtask

  task automatic op_only(input logic [7:0] op);
    logic [7:0] rx;
    begin_tx();
    xfer(op, rx, 8);
    end_tx();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rx, a, v;
    for (int i = 0; i < 32; i++) mreg[i] = 8'h00;
    for (int i = 0; i < 64; i++) msram[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk("R2 reset so_oe", {7'd0, so_oe}, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R5: reset values and wrap 0x1F -> 0x00
    read_seq(8'h00, 33, "R5 reset regs");

    // R11: clear, then full SRAM sweep with wrap
    op_only(8'h54);
    read_seq(8'h20, 65, "R11 cleared sram");

    // R7 / R3 / R1: full burst write and read-back with wrap
    write_seq(8'h20, 64, 8'h03);
    read_seq(8'h20, 65, "R3 R1 burst read");
    read_seq(8'h5E, 4, "R4 sram wrap");

    // R5: register burst across the wrap
    write_seq(8'h1E, 3, 8'h40);
    read_seq(8'h1C, 8, "R5 reg wrap");

    // R11: clear leaves registers
    op_only(8'h54);
    for (int i = 0; i < 64; i++) msram[i] = 8'h00;
    read_seq(8'h1E, 3, "R11 regs kept");
    read_seq(8'h5C, 6, "R11 sram zero");
    write_seq(8'h20, 64, 8'h11);

    // R6: high addresses
    write_seq(8'h70, 2, 8'h99);
    read_seq(8'h6E, 4, "R6 high reads zero");
    read_seq(8'hFE, 4, "R6 pointer 0xFF to 0x00");

    // R8: partial final byte
    begin_tx();
    xfer(8'h12, rx, 8);
    xfer(8'h30, rx, 8);
    xfer(8'hA1, rx, 8);
    xfer(8'hB2, rx, 8);
    xfer(8'hC3, rx, 4);
    end_tx();
    mwrite(8'h30, 8'hA1);
    mwrite(8'h31, 8'hB2);
    read_seq(8'h30, 3, "R8 partial dropped");

    // R12: unknown instruction
    begin_tx();
    xfer(8'h03, rx, 8);
    xfer(8'h50, rx, 8);
    xfer(8'hAA, rx, 8);
    xfer(8'h55, rx, 8);
    end_tx();
    chk("R12 so_oe quiet", {7'd0, oe_any}, 8'h00);
    read_seq(8'h50, 2, "R12 nothing written");

    // R9: battery blocks everything
    @(negedge clk);
    on_battery = 1'b1;
    repeat (4) @(negedge clk);
    begin_tx();
    xfer(8'h12, rx, 8);
    xfer(8'h45, rx, 8);
    xfer(8'h5A, rx, 8);
    end_tx();
    op_only(8'h54);
    begin_tx();
    xfer(8'h13, rx, 8);
    xfer(8'h45, rx, 8);
    xfer(8'h00, rx, 8);
    end_tx();
    chk("R9 so_oe on battery", {7'd0, oe_any}, 8'h00);
    on_battery = 1'b0;
    repeat (4) @(negedge clk);
    read_seq(8'h44, 3, "R9 contents kept");

    // R10: battery arrival against the commit edge
    for (int k = 0; k < 6; k++) begin
      a = 8'h48 + 8'(k);
      v = ~mread(a);
      begin_tx();
      xfer(8'h12, rx, 8);
      xfer(a, rx, 8);
      xfer(v, rx, 8);
      repeat (HP) @(negedge clk);
      cs_n = 1'b1;
      repeat (k) @(negedge clk);
      on_battery = 1'b1;
      repeat (6) @(negedge clk);
      on_battery = 1'b0;
      repeat (4) @(negedge clk);
      if (k >= 3) mwrite(a, v);
      read_seq(a, 1, "R10 commit vs battery");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule